// File: doc/BRIEF.md
# Descriptor Fetch Arbiter with Group Lock

This block decides which pipe of a shared multi-pipe DMA engine fetches its next descriptor. Every pipe keeps a count of descriptors posted to it and presents the descriptor at the head of its queue. Each clock, the arbiter takes one descriptor from one pipe that has work and is not shut out. It pulses a fetch strobe and passes on the pipe number and the descriptor. With no lock held, pipes take turns in a rotating order.

A fetched descriptor can be a command or a data descriptor. A command descriptor can carry a lock request or a release request. A lock request from a pipe gives its pipe group sole use of descriptor fetching. Every pipe whose group ID differs is then frozen until the locking group fetches a release command. Work posted to a frozen pipe is still counted and is fetched after the release. Software sets each pipe's group ID, so several pipes can share one lock session. This lets separate execution environments make a run of register writes and data transfers without another environment cutting in. Such a run is a lock command, then data descriptors, then a release command.

Top module: `dfl_fetch_lock_arb`

## Requirements
- R1: After reset no fetch strobe is raised, no lock is held, no pipe is frozen, the error flag is low, every pending count is zero, the group ID of pipe p is p, and the rotation starts at pipe 0.
- R2: A pipe is eligible at a clock edge when its pending count is nonzero and it is not frozen. If any pipe is eligible, in the cycle after that edge the block raises the fetch strobe, gives the pipe number and gives that pipe's head descriptor. It takes one descriptor per grant and decrements that pipe's count. A post in the same cycle still counts.
- R3: The search for an eligible pipe starts at the pipe after the last granted one and wraps from the highest pipe to pipe 0.
- R4: When a lock command is fetched with no lock held, the lock indication rises in the same cycle as the strobe. The locking group is the group ID of the fetching pipe.
- R5: While a lock is held, the frozen output is high for every pipe whose group ID differs from the locking group and low for the rest. A frozen pipe is never granted.
- R6: Descriptor bit DESC_W-1 is 1 for a command and 0 for data, bit DESC_W-2 is the lock request and bit DESC_W-3 is the release request. On a data descriptor both request bits have no effect on lock state or error flag.
- R7: Posts to a frozen pipe are counted, and all of them are fetched after the release.
- R8: A lock command fetched while a lock is held changes neither the lock nor the locking group.
- R9: A release command fetched while a lock is held frees every frozen pipe in the same cycle as the strobe. A release command fetched with no lock held changes nothing but sets the error flag. The flag stays set until reset.
- R10: A command with both request bits set acts as a release.
- R11: A group ID write takes effect from the next cycle. Pipes with equal group IDs are served together during a lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_i | input | NUM_PIPES | One-cycle pulse per pipe: one more descriptor posted |
| head_desc_i | input | NUM_PIPES*DESC_W | Head descriptor of each pipe's queue, pipe p at bits p*DESC_W and up |
| gid_we_i | input | 1 | Group ID write enable |
| gid_idx_i | input | PIPE_IW | Pipe whose group ID is written |
| gid_val_i | input | GID_W | New group ID |
| fetch_stb_o | output | 1 | One descriptor fetched this cycle |
| fetch_pipe_o | output | PIPE_IW | Pipe the descriptor came from |
| fetch_desc_o | output | DESC_W | Fetched descriptor |
| locked_o | output | NUM_PIPES | Per-pipe frozen status |
| lock_active_o | output | 1 | A group lock is held |
| unlock_err_o | output | 1 | Sticky: a release arrived with no lock held |

## Verification
The hardest situation to reach is a pipe that gets new work while frozen, followed by a release. A correct block must then pick up the frozen pipe's backlog at the right place in the rotation, with no post lost. The stimulus first posts a lock command on one pipe, then a trail of data descriptors behind it. Before the release, it posts bursts to the other pipes, so a backlog builds up in the frozen pipes. A behavioural model then follows every grant through the release and the drain. A second session changes a group ID at run time so that two pipes share a lock. Other sessions send a repeated lock, a combined lock-and-release command, data descriptors with request bits set, and a stray release.

// File: rtl/dfl_pkg.sv
package dfl_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_LOCK   = 2'd1,
    ACT_UNLOCK = 2'd2
  } lock_act_t;

  // f = {command, lock request, release request}; release wins over lock
  function automatic lock_act_t decode_act(input logic [2:0] f);
    if (!f[2]) return ACT_NONE;
    if (f[0])  return ACT_UNLOCK;
    if (f[1])  return ACT_LOCK;
    return ACT_NONE;
  endfunction
endpackage

// File: rtl/dfl_pend_ctr.sv
module dfl_pend_ctr #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic post,
  input  logic take,
  output logic nonzero,
  output logic at_max
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else begin
      case ({post, take})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign nonzero = (cnt != '0);
  assign at_max  = (cnt == MAXV);
endmodule

// File: rtl/dfl_rr_pick.sv
module dfl_rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          gnt_vld,
  output logic [IW-1:0] gnt_idx,
  output logic [N-1:0]  gnt_oh
);
  always_comb begin
    int unsigned j;
    gnt_vld = 1'b0;
    gnt_idx = '0;
    gnt_oh  = '0;
    for (int k = 0; k < N; k++) begin
      j = (int'(ptr) + k) % N;
      if (!gnt_vld && req[j]) begin
        gnt_vld   = 1'b1;
        gnt_idx   = IW'(j);
        gnt_oh[j] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dfl_lock_ctrl.sv
module dfl_lock_ctrl
  import dfl_pkg::*;
#(
  parameter int NP = 4,
  parameter int GW = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  lock_act_t          act,
  input  logic [GW-1:0]      src_gid,
  input  logic [NP*GW-1:0]   gid_flat,
  output logic               held,
  output logic [GW-1:0]      hold_gid,
  output logic [NP-1:0]      frozen,
  output logic               err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held     <= 1'b0;
      hold_gid <= '0;
      err      <= 1'b0;
    end else if (fire) begin
      case (act)
        ACT_LOCK: begin
          if (!held) begin
            held     <= 1'b1;
            hold_gid <= src_gid;
          end
        end
        ACT_UNLOCK: begin
          if (held) held <= 1'b0;
          else      err  <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_frz
    assign frozen[p] = held && (gid_flat[p*GW +: GW] != hold_gid);
  end
endmodule

// File: rtl/dfl_fetch_lock_arb.sv
module dfl_fetch_lock_arb
  import dfl_pkg::*;
#(
  parameter int NUM_PIPES = 4,
  parameter int DESC_W    = 32,
  parameter int CNT_W     = 4,
  parameter int GID_W     = 2,
  localparam int PIPE_IW  = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PIPES-1:0]        post_i,
  input  logic [NUM_PIPES*DESC_W-1:0] head_desc_i,
  input  logic                        gid_we_i,
  input  logic [PIPE_IW-1:0]          gid_idx_i,
  input  logic [GID_W-1:0]            gid_val_i,
  output logic                        fetch_stb_o,
  output logic [PIPE_IW-1:0]          fetch_pipe_o,
  output logic [DESC_W-1:0]           fetch_desc_o,
  output logic [NUM_PIPES-1:0]        locked_o,
  output logic                        lock_active_o,
  output logic                        unlock_err_o
);
  // named internal events, used by the checker
  logic [NUM_PIPES-1:0]       pend_nz;
  logic [NUM_PIPES-1:0]       pend_at_max;
  logic [NUM_PIPES-1:0]       eligible;
  logic                       grant_vld;
  logic [PIPE_IW-1:0]         grant_idx;
  logic [NUM_PIPES-1:0]       grant_oh;
  logic [PIPE_IW-1:0]         rr_ptr;
  logic [DESC_W-1:0]          head_sel;
  lock_act_t                  fetch_act;
  logic [NUM_PIPES*GID_W-1:0] gid_flat;
  logic [GID_W-1:0]           src_gid;
  logic [GID_W-1:0]           lock_gid;

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    dfl_pend_ctr #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .post    (post_i[p]),
      .take    (grant_oh[p]),
      .nonzero (pend_nz[p]),
      .at_max  (pend_at_max[p])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)
        gid_flat[p*GID_W +: GID_W] <= GID_W'(p);
      else if (gid_we_i && (int'(gid_idx_i) == p))
        gid_flat[p*GID_W +: GID_W] <= gid_val_i;
    end
  end

  assign eligible = pend_nz & ~locked_o;

  dfl_rr_pick #(.N(NUM_PIPES), .IW(PIPE_IW)) u_pick (
    .req     (eligible),
    .ptr     (rr_ptr),
    .gnt_vld (grant_vld),
    .gnt_idx (grant_idx),
    .gnt_oh  (grant_oh)
  );

  assign head_sel  = head_desc_i[int'(grant_idx)*DESC_W +: DESC_W];
  assign fetch_act = grant_vld ? decode_act(head_sel[DESC_W-1 -: 3]) : ACT_NONE;
  assign src_gid   = gid_flat[int'(grant_idx)*GID_W +: GID_W];

  dfl_lock_ctrl #(.NP(NUM_PIPES), .GW(GID_W)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (grant_vld),
    .act      (fetch_act),
    .src_gid  (src_gid),
    .gid_flat (gid_flat),
    .held     (lock_active_o),
    .hold_gid (lock_gid),
    .frozen   (locked_o),
    .err      (unlock_err_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr       <= '0;
      fetch_stb_o  <= 1'b0;
      fetch_pipe_o <= '0;
      fetch_desc_o <= '0;
    end else begin
      fetch_stb_o <= grant_vld;
      if (grant_vld) begin
        fetch_pipe_o <= grant_idx;
        fetch_desc_o <= head_sel;
        rr_ptr       <= (int'(grant_idx) == NUM_PIPES-1) ? '0 : grant_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dfl_checker.sv
module dfl_checker #(
  parameter int NUM_PIPES = 4,
  parameter int DESC_W    = 32,
  parameter int GID_W     = 2,
  parameter int PIPE_IW   = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_PIPES-1:0] post_i,
  input logic                 grant_vld,
  input logic [PIPE_IW-1:0]   grant_idx,
  input logic [NUM_PIPES-1:0] grant_oh,
  input logic [NUM_PIPES-1:0] pend_at_max,
  input logic [NUM_PIPES-1:0] locked_o,
  input logic                 lock_active_o,
  input logic [GID_W-1:0]     lock_gid,
  input logic                 fetch_stb_o,
  input logic [DESC_W-1:0]    fetch_desc_o,
  input logic                 unlock_err_o
);
  // R2
  grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_oh));

  // R5
  grant_unfrozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> !locked_o[grant_idx]);

  // R5
  idle_nofreeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_active_o |-> (locked_o == '0));

  // R4
  lock_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stb_o && fetch_desc_o[DESC_W-1] && fetch_desc_o[DESC_W-2] && !fetch_desc_o[DESC_W-3])
      |-> lock_active_o);

  // R9
  release_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stb_o && fetch_desc_o[DESC_W-1] && fetch_desc_o[DESC_W-3]) |-> !lock_active_o);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(unlock_err_o) |-> unlock_err_o);

  // R8
  owner_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lock_active_o) && lock_active_o) |-> $stable(lock_gid));

  // R7
  pend_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (post_i & pend_at_max & ~grant_oh) == '0);
endmodule

bind dfl_fetch_lock_arb dfl_checker #(
  .NUM_PIPES (NUM_PIPES),
  .DESC_W    (DESC_W),
  .GID_W     (GID_W),
  .PIPE_IW   (PIPE_IW)
) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .post_i        (post_i),
  .grant_vld     (grant_vld),
  .grant_idx     (grant_idx),
  .grant_oh      (grant_oh),
  .pend_at_max   (pend_at_max),
  .locked_o      (locked_o),
  .lock_active_o (lock_active_o),
  .lock_gid      (lock_gid),
  .fetch_stb_o   (fetch_stb_o),
  .fetch_desc_o  (fetch_desc_o),
  .unlock_err_o  (unlock_err_o)
);

// File: tb/test_dfl_fetch_lock_arb.sv
module test_dfl_fetch_lock_arb;
  localparam int NP = 4;
  localparam int DW = 32;
  localparam int IW = 2;
  localparam int GW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]    post_i = '0;
  logic [NP*DW-1:0] head_desc_i = '0;
  logic             gid_we_i = 1'b0;
  logic [IW-1:0]    gid_idx_i = '0;
  logic [GW-1:0]    gid_val_i = '0;
  logic             fetch_stb_o;
  logic [IW-1:0]    fetch_pipe_o;
  logic [DW-1:0]    fetch_desc_o;
  logic [NP-1:0]    locked_o;
  logic             lock_active_o;
  logic             unlock_err_o;

  always #10 clk = ~clk;

  dfl_fetch_lock_arb i_dfl_fetch_lock_arb (
    .clk(clk), .rst_n(rst_n), .post_i(post_i), .head_desc_i(head_desc_i),
    .gid_we_i(gid_we_i), .gid_idx_i(gid_idx_i), .gid_val_i(gid_val_i),
    .fetch_stb_o(fetch_stb_o), .fetch_pipe_o(fetch_pipe_o), .fetch_desc_o(fetch_desc_o),
    .locked_o(locked_o), .lock_active_o(lock_active_o), .unlock_err_o(unlock_err_o)
  );

  // reference model state
  logic [DW-1:0] q[NP][$];
  int  gid_m[NP];
  bit  held_m;
  int  hgid_m;
  bit  err_m;
  int  rr_m;
  bit  exp_stb;
  int  exp_pipe;
  logic [DW-1:0] exp_desc;
  logic [NP-1:0] exp_locked;

  // pending stimulus for the next cycle
  logic [NP-1:0] nxt_post;
  logic [DW-1:0] nxt_desc[NP];
  bit  nxt_gwe;
  int  nxt_gidx, nxt_gval;

  int vectors = 0;
  int fails = 0;
  string cur_req = "R1";

  function automatic logic [DW-1:0] mk(bit cmd, bit lk, bit ul, int pay);
    logic [DW-1:0] d;
    d = DW'(pay);
    d[DW-1] = cmd; d[DW-2] = lk; d[DW-3] = ul;
    return d;
  endfunction

  task automatic chk(string what, string req, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic post(int p, logic [DW-1:0] d);
    nxt_post[p] = 1'b1;
    nxt_desc[p] = d;
  endtask

  task automatic cycle();
    int sz[NP];
    int g;
    bit cmd, lk, ul;
    @(negedge clk);
    chk("strobe", cur_req, fetch_stb_o, exp_stb);
    if (exp_stb) begin
      chk("pipe (R3)", cur_req, fetch_pipe_o, exp_pipe);
      chk("desc (R2)", cur_req, fetch_desc_o, exp_desc);
    end
    chk("frozen (R5)", cur_req, locked_o, exp_locked);
    chk("lock (R4)", cur_req, lock_active_o, held_m);
    chk("err (R9)", cur_req, unlock_err_o, err_m);
    if (exp_stb) void'(q[exp_pipe].pop_front());
    for (int p = 0; p < NP; p++) sz[p] = q[p].size();
    // drive
    post_i = nxt_post;
    for (int p = 0; p < NP; p++) if (nxt_post[p] && q[p].size() < 14) q[p].push_back(nxt_desc[p]);
    for (int p = 0; p < NP; p++)
      head_desc_i[p*DW +: DW] = (q[p].size() > 0) ? q[p][0] : '0;
    gid_we_i  = nxt_gwe;
    gid_idx_i = IW'(nxt_gidx);
    gid_val_i = GW'(nxt_gval);
    // model the coming edge
    g = -1;
    for (int k = 0; k < NP; k++) begin
      int j = (rr_m + k) % NP;
      bit frz = held_m && (gid_m[j] != hgid_m);
      if (g < 0 && sz[j] > 0 && !frz) g = j;
    end
    exp_stb = (g >= 0);
    if (g >= 0) begin
      exp_pipe = g;
      exp_desc = q[g][0];
      cmd = exp_desc[DW-1]; lk = exp_desc[DW-2]; ul = exp_desc[DW-3];
      if (cmd && ul) begin
        if (held_m) held_m = 0; else err_m = 1;
      end else if (cmd && lk) begin
        if (!held_m) begin held_m = 1; hgid_m = gid_m[g]; end
      end
      rr_m = (g + 1) % NP;
    end
    if (nxt_gwe) gid_m[nxt_gidx] = nxt_gval;
    for (int p = 0; p < NP; p++) exp_locked[p] = held_m && (gid_m[p] != hgid_m);
    nxt_post = '0; nxt_gwe = 0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((q[0].size() + q[1].size() + q[2].size() + q[3].size()) > 0 && guard < 200) begin
      cycle(); guard++;
    end
    repeat (2) cycle();
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) gid_m[p] = p;
    held_m = 0; hgid_m = 0; err_m = 0; rr_m = 0;
    exp_stb = 0; exp_pipe = 0; exp_desc = '0; exp_locked = '0;
    nxt_post = '0; nxt_gwe = 0; nxt_gidx = 0; nxt_gval = 0;
    for (int p = 0; p < NP; p++) nxt_desc[p] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    cur_req = "R1";
    repeat (3) cycle();

    // R2 / R3: rotation over mixed patterns
    cur_req = "R3";
    for (int i = 0; i < 4; i++) begin
      post(0, mk(0, 0, 0, 16'h100 + i));
      post(2, mk(0, 0, 0, 16'h200 + i));
      if (i % 2 == 0) post(3, mk(0, 0, 0, 16'h300 + i));
      cycle();
    end
    drain();
    cur_req = "R2";
    post(1, mk(0, 0, 0, 16'h111)); cycle();
    post(1, mk(0, 0, 0, 16'h112)); post(0, mk(0, 0, 0, 16'h011)); cycle();
    drain();

    // R6: data descriptors with request bits set
    cur_req = "R6";
    post(1, mk(0, 1, 0, 16'h610)); cycle();
    post(1, mk(0, 0, 1, 16'h611)); cycle();
    post(2, mk(0, 1, 1, 16'h612)); cycle();
    drain();

    // R4 / R5 / R7 / R8: lock session on pipe 1 with backlog on others
    cur_req = "R4";
    post(1, mk(1, 1, 0, 16'h4A0)); cycle();
    cur_req = "R7";
    for (int i = 0; i < 5; i++) begin
      post(1, mk(0, 0, 0, 16'h710 + i));
      post(0, mk(0, 0, 0, 16'h700 + i));
      post(3, mk(0, 0, 0, 16'h730 + i));
      cycle();
    end
    cur_req = "R8";
    post(1, mk(1, 1, 0, 16'h8A0)); cycle();
    post(2, mk(0, 0, 0, 16'h820)); cycle();
    repeat (4) cycle();
    cur_req = "R9";
    post(1, mk(1, 0, 1, 16'h9B0)); cycle();
    cur_req = "R7";
    drain();

    // R11: pipe 2 joins group 3, lock from pipe 3
    cur_req = "R11";
    nxt_gwe = 1; nxt_gidx = 2; nxt_gval = 3; cycle();
    post(3, mk(1, 1, 0, 16'hB30)); cycle();
    for (int i = 0; i < 3; i++) begin
      post(2, mk(0, 0, 0, 16'hB20 + i));
      post(3, mk(0, 0, 0, 16'hB38 + i));
      post(0, mk(0, 0, 0, 16'hB00 + i));
      post(1, mk(0, 0, 0, 16'hB10 + i));
      cycle();
    end
    repeat (4) cycle();
    post(2, mk(1, 0, 1, 16'hB2F)); cycle();
    drain();

    // R10: both request bits release a held lock
    cur_req = "R10";
    post(0, mk(1, 1, 0, 16'hA00)); cycle();
    post(0, mk(0, 0, 0, 16'hA01)); post(1, mk(0, 0, 0, 16'hA11)); cycle();
    repeat (2) cycle();
    post(0, mk(1, 1, 1, 16'hA0F)); cycle();
    drain();

    // R9: stray release raises sticky error
    cur_req = "R9";
    post(3, mk(1, 0, 1, 16'h9F0)); cycle();
    post(1, mk(0, 0, 0, 16'h9F1)); cycle();
    drain();
    post(2, mk(1, 1, 0, 16'h9C0)); cycle();
    post(2, mk(1, 0, 1, 16'h9C1)); cycle();
    drain();

    summary();
    $finish;
  end
endmodule